// File: doc/BRIEF.md
# Ramped Soft-Mute Attenuator

This block sits in a digital audio sample path and scales stereo 24-bit two's-complement samples by a gain that moves gradually rather than jumping. The gain is an integer level from 0 (silence) to 1024 (unity). The level moves by one step on every sample strobe. While the mute control is high, the level falls towards zero. While it is low, the level climbs back towards unity. Because the block simply follows the mute control on every strobe, a change of mute in the middle of a ramp turns the ramp around from the level already reached.

Each strobe loads one scaled left/right pair into the output registers. The pair appears one clock later, together with an output strobe. The left and right channels always use the same level. A power-down input forces both outputs to zero and clears the level. When power-down is released with mute low, the output fades back in from silence. A flag reports when the output is held at silence by the mute control.

Top module: `soft_mute_ramp`

## Requirements
- R1: While reset is asserted (synchronous, active low), the level becomes 1024, both sample outputs become zero, and the output strobe becomes low. With mute low after reset, the muted flag is low.
- R2: On each input strobe with mute high and power-down low, the level drops by one. It stops at 0, so 1024 strobes take it from unity to zero. A sample taken at level 0 is output as exactly zero.
- R3: On each input strobe with mute low and power-down low, the level rises by one. It stops at 1024. A sample taken at level 1024 is output unchanged, including the extremes 0x7FFFFF and 0x800000.
- R4: If mute changes while a ramp is in progress, the next strobe moves the level one step in the new direction, starting from the level already reached.
- R5: Each output sample equals the input sample times the current level, divided by 1024, with the quotient rounded toward zero. The level used is the one held before that strobe's step.
- R6: The left and right samples taken on the same strobe are scaled by the same level.
- R7: In a cycle with no input strobe and power-down low, the level and both sample outputs keep their values.
- R8: In any cycle in which power-down is high, the level is set to 0, and both sample outputs become zero at the next clock edge. After power-down is released with mute low, the level climbs from 0.
- R9: The muted flag is high exactly when the mute control is high and the level is 0.
- R10: The output strobe follows the input strobe with a delay of one clock cycle. The sample outputs change only at the edge that follows an input strobe or a power-down cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_dn | input | 1 | Power-down; zeroes the outputs and clears the level |
| mute | input | 1 | High: ramp down; low: ramp up |
| in_vld | input | 1 | Sample strobe, one per word-clock period |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_vld | output | 1 | Output strobe, one cycle after in_vld |
| out_l | output | 24 | Attenuated left sample |
| out_r | output | 24 | Attenuated right sample |
| muted | output | 1 | High while mute is high and the level is zero |

## Verification
Some properties are checked on every cycle. The level moves by exactly one step in the direction set by mute and stops at both ends. It holds when there is no strobe. Samples taken at level zero, or during power-down, come out as zero. The product never overflows the output width. A strobe with equal left and right inputs gives equal outputs.

Other behaviour can only be shown by the bench's scenarios. These are the exact rounded value of each scaled sample, the 1024-strobe length of each full ramp, and the turn-around from an intermediate level when mute changes mid-ramp. They also include the fade-in from silence after power-down, and the timing of the muted flag as the level reaches zero.

// File: rtl/smr_pkg.sv
// Package: shared types for the ramped soft-mute attenuator.
// Assumes: nothing beyond IEEE 1800-2017.
package smr_pkg;

    // Direction in which the shared gain level moves on a sample strobe.
    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    // Number of stereo channels that share one gain level.
    localparam int SMR_NUM_CH = 2;

endpackage

// File: rtl/smr_gain_ctrl.sv
// Module: smr_gain_ctrl
// Holds the shared gain level, from 0 up to 2**RAMP_LOG2 (unity). On each
// step strobe the level moves by one towards zero while mute is high, and
// towards unity while mute is low. It stops at both ends. Power-down clears
// the level. Reset sets it to unity.
// Assumes: step_en is a one-cycle strobe per sample period.
module smr_gain_ctrl
    import smr_pkg::*;
#(
    parameter int RAMP_LOG2 = 10,
    localparam int GW = RAMP_LOG2 + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_dn,
    input  logic          mute,
    input  logic          step_en,
    output logic [GW-1:0] gain,
    output logic          at_floor
);

    localparam logic [GW-1:0] FULL = {1'b1, {RAMP_LOG2{1'b0}}};
    localparam logic [GW-1:0] ONE  = GW'(1);

    ramp_dir_e dir;
    logic      at_top;

    // Decode the ramp direction and the end-stop conditions.
    always_comb begin
        dir      = mute ? RAMP_DOWN : RAMP_UP;
        at_top   = (gain == FULL);
        at_floor = (gain == '0);
    end

    // Level register: reset to unity, cleared by power-down, stepped on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain <= FULL;
        end else if (pwr_dn) begin
            gain <= '0;
        end else if (step_en) begin
            if (dir == RAMP_DOWN && !at_floor) begin
                gain <= gain - ONE;
            end else if (dir == RAMP_UP && !at_top) begin
                gain <= gain + ONE;
            end
        end
    end

    AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= FULL);  // R3

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_en) && $past(mute) && !$past(pwr_dn) && $past(gain) != '0)
        |-> (gain == $past(gain) - ONE));  // R2

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_en) && !$past(mute) && !$past(pwr_dn) && $past(gain) != FULL)
        |-> (gain == $past(gain) + ONE));  // R3

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_en) && !$past(pwr_dn)) |-> $stable(gain));  // R7

endmodule

// File: rtl/smr_scale.sv
// Module: smr_scale
// One channel of the datapath. It multiplies a signed sample by the gain
// level, divides by 2**RAMP_LOG2 with the quotient rounded toward zero, and
// registers the result on each load strobe. Power-down zeroes the register.
// Assumes: gain never exceeds 2**RAMP_LOG2, so the result fits DATA_W bits.
module smr_scale #(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 10,
    localparam int GW = RAMP_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic [GW-1:0]     gain,
    output logic [DATA_W-1:0] dout
);

    localparam int PW = DATA_W + GW + 1;
    localparam int HW = PW - RAMP_LOG2 - DATA_W + 1;

    logic signed [PW-1:0] din_x;
    logic signed [PW-1:0] gain_x;
    logic signed [PW-1:0] prod;
    logic [DATA_W-1:0]    q_floor;
    logic [DATA_W-1:0]    scaled;
    logic [HW-1:0]        hi_bits;
    logic                 neg;
    logic                 rem_nz;

    // Signed product, then a floor shift corrected to round toward zero.
    always_comb begin
        din_x   = {{(GW + 1){din[DATA_W-1]}}, din};
        gain_x  = {{(DATA_W + 1){1'b0}}, gain};
        prod    = din_x * gain_x;
        neg     = prod[PW-1];
        rem_nz  = |prod[RAMP_LOG2-1:0];
        q_floor = prod[RAMP_LOG2 +: DATA_W];
        hi_bits = prod[PW-1 -: HW];
        scaled  = q_floor + {{(DATA_W - 1){1'b0}}, (neg & rem_nz)};
    end

    // Output register: zero on reset and power-down, loaded on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (pwr_dn) begin
            dout <= '0;
        end else if (load) begin
            dout <= scaled;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ((&hi_bits) || (~|hi_bits)));  // R5

endmodule

// File: rtl/soft_mute_ramp.sv
// Module: soft_mute_ramp (top)
// Stereo ramped soft-mute attenuator. One shared gain level scales both
// channels. The level ramps down while mute is high and up while it is low,
// one step per sample strobe. Scaled samples appear one cycle after their
// strobe. Power-down forces silence and clears the level.
// Assumes: in_vld pulses once per word-clock period; samples are two's complement.
module soft_mute_ramp
    import smr_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int RAMP_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              mute,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              muted
);

    localparam int GW = RAMP_LOG2 + 1;

    logic [GW-1:0]     gain_q;
    logic              floor_q;
    logic [DATA_W-1:0] ch_in  [SMR_NUM_CH];
    logic [DATA_W-1:0] ch_out [SMR_NUM_CH];

    smr_gain_ctrl #(
        .RAMP_LOG2 (RAMP_LOG2)
    ) u_gain (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .mute     (mute),
        .step_en  (in_vld),
        .gain     (gain_q),
        .at_floor (floor_q)
    );

    // Gather the channel inputs into an array for the generated datapaths.
    always_comb begin
        ch_in[0] = in_l;
        ch_in[1] = in_r;
    end

    for (genvar ch = 0; ch < SMR_NUM_CH; ch++) begin : g_ch
        smr_scale #(
            .DATA_W    (DATA_W),
            .RAMP_LOG2 (RAMP_LOG2)
        ) u_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr_dn (pwr_dn),
            .load   (in_vld),
            .din    (ch_in[ch]),
            .gain   (gain_q),
            .dout   (ch_out[ch])
        );
    end

    // Drive the outputs from the channel array and the floor/mute state.
    always_comb begin
        out_l = ch_out[0];
        out_r = ch_out[1];
        muted = mute & floor_q;
    end

    // Output strobe register, one cycle behind the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
        end
    end

    AST_PDN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pwr_dn)) |-> (out_l == '0 && out_r == '0));  // R8

    AST_FLOOR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld) && $past(gain_q) == '0)
        |-> (out_l == '0 && out_r == '0));  // R2

    AST_SHARED_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld) && $past(in_l) == $past(in_r))
        |-> (out_l == out_r));  // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_vld) && !$past(pwr_dn))
        |-> ($stable(out_l) && $stable(out_r)));  // R7

endmodule

// File: tb/soft_mute_ramp_tb.sv
// Bench for soft_mute_ramp. A behavioural reference model of the gain level
// is compared with the outputs on every clock.
module soft_mute_ramp_tb;

    localparam int CLK_PERIOD = 10;
    localparam int UNITY      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        mute = 1'b0;
    logic        in_vld = 1'b0;
    logic [23:0] in_l = '0;
    logic [23:0] in_r = '0;
    logic        out_vld;
    logic [23:0] out_l;
    logic [23:0] out_r;
    logic        muted;

    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    int          model_gain = UNITY;
    int          exp_l = 0;
    int          exp_r = 0;
    int unsigned seed = 32'h1234_5678;

    soft_mute_ramp u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_dn  (pwr_dn),
        .mute    (mute),
        .in_vld  (in_vld),
        .in_l    (in_l),
        .in_r    (in_r),
        .out_vld (out_vld),
        .out_l   (out_l),
        .out_r   (out_r),
        .muted   (muted)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int scale_ref(input logic [23:0] s, input int g);
        longint p;
        p = longint'($signed(s)) * longint'(g);
        return int'(p / 1024);
    endfunction

    // One clock: drive at the falling edge, update the model, compare after the rising edge.
    task automatic cyc(input bit v, input bit m, input bit p,
                       input logic [23:0] l, input logic [23:0] r, input string tag);
        @(negedge clk);
        in_vld = v; mute = m; pwr_dn = p; in_l = l; in_r = r;
        @(posedge clk);
        #1;
        if (p) begin
            exp_l = 0; exp_r = 0; model_gain = 0;
        end else if (v) begin
            exp_l = scale_ref(l, model_gain);
            exp_r = scale_ref(r, model_gain);
            if (m) model_gain = (model_gain > 0) ? model_gain - 1 : 0;
            else   model_gain = (model_gain < UNITY) ? model_gain + 1 : UNITY;
        end
        check(int'($signed(out_l)) == exp_l, tag, "out_l", int'($signed(out_l)), exp_l);
        check(int'($signed(out_r)) == exp_r, tag, "out_r", int'($signed(out_r)), exp_r);
        check(out_vld == v, "R10", "out_vld", int'(out_vld), int'(v));
        check(muted == (m && model_gain == 0), "R9", "muted", int'(muted),
              int'(m && model_gain == 0));
    endtask

    task automatic rnd(output logic [23:0] v);
        seed = seed * 32'd1664525 + 32'd1013904223;
        v = seed[31:8];
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        logic [23:0] a;
        logic [23:0] b;
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check(out_l == '0, "R1", "out_l", int'(out_l), 0);
        check(out_r == '0, "R1", "out_r", int'(out_r), 0);
        check(out_vld == 1'b0, "R1", "out_vld", int'(out_vld), 0);
        check(muted == 1'b0, "R1", "muted", int'(muted), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_gain = UNITY;

        // R3: unity passes the extremes unchanged; R10 strobe timing
        cyc(1, 0, 0, 24'h7FFFFF, 24'h800000, "R3");
        cyc(1, 0, 0, 24'h000001, 24'hFFFFFF, "R3");
        cyc(0, 0, 0, 24'h123456, 24'h654321, "R10");

        // R2/R5/R7: full down-ramp with random samples and strobe gaps
        for (int i = 0; i < 1200; i++) begin
            rnd(a); rnd(b);
            if (i % 7 == 3) cyc(0, 1, 0, a, b, "R7");
            else if (i % 5 == 0) cyc(1, 1, 0, a, a, "R6");
            else cyc(1, 1, 0, a, b, (i % 2 == 0) ? "R2" : "R5");
        end
        // R2: at the floor the output is exactly zero
        cyc(1, 1, 0, 24'h7FFFFF, 24'h800000, "R2");

        // R3: climb part way, then R4: reverse down, then reverse up again
        for (int i = 0; i < 300; i++) begin
            rnd(a); rnd(b); cyc(1, 0, 0, a, b, "R3");
        end
        for (int i = 0; i < 100; i++) begin
            rnd(a); rnd(b); cyc(1, 1, 0, a, b, "R4");
        end
        for (int i = 0; i < 50; i++) begin
            cyc(1, 0, 0, 24'h800000, 24'h7FFFFF, "R4");
        end

        // R3: full climb to unity and saturate there
        for (int i = 0; i < 1100; i++) begin
            rnd(a); rnd(b); cyc(1, 0, 0, a, b, "R3");
        end
        cyc(1, 0, 0, 24'h800001, 24'h7FFFFE, "R3");

        // R8: power-down zeroes outputs and clears the level, then fade in from zero
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, 24'h400000, 24'hC00000, "R8");
        cyc(0, 0, 1, 24'h400000, 24'hC00000, "R8");
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, 24'h7FFFFF, 24'h800000, "R8");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule